// File: doc/BRIEF.md
# Bit Count Unit With Flags

This unit counts bits in one operand per transfer. A two-bit operation code picks one of three counts: set bits, zero bits above the highest set bit, or zero bits below the lowest set bit. A width select makes the operand 64 bits or only its low 32 bits. Beside the count, the unit returns two flags. One flag marks a count of zero. The other marks a source that has no set bit. It also returns the two bit-scan indices of the operand: the position of the lowest set bit and the position of the highest set bit. These let the result be compared with a plain priority encoder.

Operands enter through a valid/ready handshake. The result comes out of a single registered stage with its own valid/ready pair. The stage can take a new operand on every cycle as long as the consumer keeps ready high. When the consumer stalls, the stage holds its result unchanged.

Top module: `bit_count_unit`

## Requirements
- R1: The operation code on `in_op` is 0 for population count, 1 for leading-zero count and 2 for trailing-zero count. Population count returns the number of set bits in the operand and always clears `out_cf`.
- R2: For a nonzero operand, leading-zero count returns the number of zero bits above the highest set bit. That count plus `out_rev` equals the operand width minus one. A 32-bit operand of 0x000f0000 gives a count of 12 and `out_rev` of 19.
- R3: For a nonzero operand, trailing-zero count returns the number of zero bits below the lowest set bit, and this equals `out_fwd`.
- R4: For an all-zero operand, leading-zero and trailing-zero counts both return the operand width (32 or 64) and set `out_cf`. The unit reports both `out_fwd` and `out_rev` as 0 for an all-zero operand.
- R5: `out_zf` is 1 exactly when `out_count` is 0, for every operation.
- R6: When `in_wide` is 0, bits 63..32 of `in_src` are ignored. The operand is then bits 31..0, and the count and both indices never exceed 32 and 31.
- R7: `in_ready` is high when `out_valid` is low or `out_ready` is high. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high, and its result shows on the outputs with `out_valid` high after that edge. With no new operand and `out_ready` high, `out_valid` falls after the edge.
- R8: While `out_valid` is high and `out_ready` is low, the outputs hold their values and `out_valid` stays high, whatever the inputs do.
- R9: While synchronous reset `rst` is high, `out_valid`, `out_count`, both flags and both indices clear to 0 on the next edge.
- R10: Operation code 3 behaves as population count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Unit can take an operand |
| in_op | input | 2 | Operation code |
| in_wide | input | 1 | 1: 64-bit operand, 0: 32-bit operand |
| in_src | input | 64 | Source operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_count | output | 7 | Selected count |
| out_zf | output | 1 | Count is zero |
| out_cf | output | 1 | Source is zero (leading/trailing counts only) |
| out_fwd | output | 6 | Index of the lowest set bit |
| out_rev | output | 6 | Index of the highest set bit |

## Verification
On every cycle, the assertions check the stall and transfer rules of the output stage. For each valid result, they also check how the count, the flags and the two scan indices relate to one another, using the operation and width that the checker itself latched at the transfer. What they cannot show is whether a count matches its operand. For that, the bench's vector table gives known operands and known answers, and directed sequences cover reset, a stalled consumer that sees changing inputs, and back-to-back transfers.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        OPC_POP  = 2'd0,
        OPC_LEAD = 2'd1,
        OPC_TRAIL = 2'd2,
        OPC_ALT  = 2'd3
    } bcu_op_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             zf;
        logic             cf;
        logic [IDX_W-1:0] fwd;
        logic [IDX_W-1:0] rev;
    } bcu_result_t;

    function automatic logic is_scan_op(input bcu_op_e op);
        return (op == OPC_LEAD) || (op == OPC_TRAIL);
    endfunction
endpackage

// File: rtl/bcu_lead_zero.sv
module bcu_lead_zero #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Later (higher) set bits overwrite earlier ones: highest set bit wins.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/bcu_popcount.sv
module bcu_popcount #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/bit_count_unit.sv
module bit_count_unit
    import bcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] in_src,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CNT_W-1:0]  out_count,
    output logic              out_zf,
    output logic              out_cf,
    output logic [IDX_W-1:0]  out_fwd,
    output logic [IDX_W-1:0]  out_rev
);
    logic [DATA_W-1:0] opnd, opnd_flip;
    logic [CNT_W-1:0]  lead_full, trail_full, pop_cnt;
    logic [CNT_W-1:0]  lead_cnt, trail_cnt;
    logic              src_zero, take;
    bcu_op_e           op;
    bcu_result_t       nxt, res_q;
    logic              valid_q;

    assign op   = bcu_op_e'(in_op);
    assign opnd = in_wide ? in_src : {{HALF_W{1'b0}}, in_src[HALF_W-1:0]};

    // Bit reversal turns the trailing scan into a second leading scan.
    for (genvar g = 0; g < DATA_W; g++) begin : g_flip
        assign opnd_flip[g] = opnd[DATA_W-1-g];
    end

    bcu_lead_zero #(.W(DATA_W), .CW(CNT_W)) u_lead (.vec(opnd),      .cnt(lead_full));
    bcu_lead_zero #(.W(DATA_W), .CW(CNT_W)) u_trail(.vec(opnd_flip), .cnt(trail_full));
    bcu_popcount  #(.W(DATA_W), .CW(CNT_W)) u_pop  (.vec(opnd),      .cnt(pop_cnt));

    assign src_zero  = ~|opnd;
    assign lead_cnt  = in_wide ? lead_full : lead_full - CNT_W'(HALF_W);
    assign trail_cnt = (!in_wide && src_zero) ? CNT_W'(HALF_W) : trail_full;

    always_comb begin
        unique case (op)
            OPC_LEAD:  nxt.count = lead_cnt;
            OPC_TRAIL: nxt.count = trail_cnt;
            default:   nxt.count = pop_cnt;
        endcase
        nxt.zf  = (nxt.count == '0);
        nxt.cf  = is_scan_op(op) && src_zero;
        nxt.fwd = src_zero ? '0 : trail_full[IDX_W-1:0];
        nxt.rev = src_zero ? '0 : IDX_W'(CNT_W'(DATA_W - 1) - lead_full);
    end

    assign in_ready = !valid_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            if (take) begin
                res_q   <= nxt;
                valid_q <= 1'b1;
            end else if (out_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_count = res_q.count;
    assign out_zf    = res_q.zf;
    assign out_cf    = res_q.cf;
    assign out_fwd   = res_q.fwd;
    assign out_rev   = res_q.rev;
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker
    import bcu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_op,
    input logic             in_wide,
    input logic             out_valid,
    input logic             out_ready,
    input logic [CNT_W-1:0] out_count,
    input logic             out_zf,
    input logic             out_cf,
    input logic [IDX_W-1:0] out_fwd,
    input logic [IDX_W-1:0] out_rev
);
    logic [1:0] op_q;
    logic       wide_q;
    int         width_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= 2'd0;
            wide_q <= 1'b1;
        end else if (in_valid && in_ready) begin
            op_q   <= in_op;
            wide_q <= in_wide;
        end
    end

    assign width_q = wide_q ? DATA_W : HALF_W;

    assert_pop_cf_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid && (op_q == 2'd0 || op_q == 2'd3) |-> !out_cf);

    assert_lead_sum_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid && op_q == 2'd1 && !out_cf |->
            int'(out_count) + int'(out_rev) == width_q - 1);

    assert_trail_idx_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid && op_q == 2'd2 && !out_cf |-> int'(out_count) == int'(out_fwd));

    assert_zero_src_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_cf |->
            int'(out_count) == width_q && out_fwd == '0 && out_rev == '0);

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_zf == (out_count == '0));

    assert_narrow_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !wide_q |-> int'(out_count) <= HALF_W && int'(out_rev) < HALF_W);

    assert_ready_R7: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid && !out_ready);

    assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_count) && $stable(out_zf)
            && $stable(out_cf) && $stable(out_fwd) && $stable(out_rev));
endmodule

bind bit_count_unit bcu_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wide(in_wide), .out_valid(out_valid), .out_ready(out_ready),
    .out_count(out_count), .out_zf(out_zf), .out_cf(out_cf),
    .out_fwd(out_fwd), .out_rev(out_rev)
);

// File: tb/sim_bit_count_unit.sv
module sim_bit_count_unit;
    import bcu_pkg::*;

    typedef struct packed {
        logic [1:0]  op;
        logic        wide;
        logic [63:0] src;
        logic [6:0]  cnt;
        logic        zf;
        logic        cf;
        logic [5:0]  fwd;
        logic [5:0]  rev;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 7'd64, 1'b0, 1'b0, 6'd0,  6'd63}, // R1
        '{2'd0, 1'b0, 64'hFFFF_FFFF_0000_000F, 7'd4,  1'b0, 1'b0, 6'd0,  6'd3},  // R1 R6
        '{2'd0, 1'b1, 64'h0,                   7'd0,  1'b1, 1'b0, 6'd0,  6'd0},  // R1 R5
        '{2'd1, 1'b0, 64'h0000_0000_000F_0000, 7'd12, 1'b0, 1'b0, 6'd16, 6'd19}, // R2
        '{2'd1, 1'b1, 64'h0000_0000_000F_0000, 7'd44, 1'b0, 1'b0, 6'd16, 6'd19}, // R2
        '{2'd1, 1'b1, 64'h0,                   7'd64, 1'b0, 1'b1, 6'd0,  6'd0},  // R4
        '{2'd1, 1'b0, 64'hAAAA_0000_0000_0000, 7'd32, 1'b0, 1'b1, 6'd0,  6'd0},  // R4 R6
        '{2'd1, 1'b1, 64'h8000_0000_0000_0000, 7'd0,  1'b1, 1'b0, 6'd63, 6'd63}, // R2 R5
        '{2'd2, 1'b1, 64'h0000_0100_0000_0000, 7'd40, 1'b0, 1'b0, 6'd40, 6'd40}, // R3
        '{2'd2, 1'b0, 64'hFFFF_0000_8000_0000, 7'd31, 1'b0, 1'b0, 6'd31, 6'd31}, // R3 R6
        '{2'd2, 1'b0, 64'h0,                   7'd32, 1'b0, 1'b1, 6'd0,  6'd0},  // R4
        '{2'd2, 1'b1, 64'h1,                   7'd0,  1'b1, 1'b0, 6'd0,  6'd0},  // R3 R5
        '{2'd3, 1'b1, 64'h0000_0000_0000_00F0, 7'd4,  1'b0, 1'b0, 6'd4,  6'd7},  // R10
        '{2'd0, 1'b0, 64'h1234_5678_0000_0000, 7'd0,  1'b1, 1'b0, 6'd0,  6'd0}   // R6 R5
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [1:0] in_op = 2'd0;
    logic in_wide = 1'b1;
    logic [63:0] in_src = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [6:0] out_count;
    logic out_zf, out_cf;
    logic [5:0] out_fwd, out_rev;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bit_count_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_wide(in_wide), .in_src(in_src),
        .out_valid(out_valid), .out_ready(out_ready), .out_count(out_count),
        .out_zf(out_zf), .out_cf(out_cf), .out_fwd(out_fwd), .out_rev(out_rev)
    );

    function automatic string tag_of(input vec_t v);
        if (v.cf)        return "R4";
        if (!v.wide)     return "R6";
        case (v.op)
            2'd1:    return "R2";
            2'd2:    return "R3";
            2'd3:    return "R10";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_result(input string req, input vec_t v);
        check(req, "valid", 64'(out_valid), 64'd1);
        check(req, "count", 64'(out_count), 64'(v.cnt));
        check("R5", "zf", 64'(out_zf), 64'(v.zf));
        check(req, "cf", 64'(out_cf), 64'(v.cf));
        check(req, "fwd", 64'(out_fwd), 64'(v.fwd));
        check(req, "rev", 64'(out_rev), 64'(v.rev));
    endtask

    task automatic drive(input vec_t v);
        in_op   = v.op;
        in_wide = v.wide;
        in_src  = v.src;
    endtask

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset clears the output stage.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", "valid", 64'(out_valid), 64'd0);
        check("R9", "count", 64'(out_count), 64'd0);
        check("R9", "flags", 64'({out_zf, out_cf}), 64'd0);
        check("R9", "index", 64'({out_fwd, out_rev}), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // Vector table, one transfer each.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            in_valid  = 1'b1;
            out_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            check_result(tag_of(VECS[i]), VECS[i]);
        end

        // R7: with nothing new and ready high, valid falls.
        @(posedge clk);
        @(negedge clk);
        check("R7", "valid drop", 64'(out_valid), 64'd0);
        check("R7", "in_ready idle", 64'(in_ready), 64'd1);

        // R8: stalled consumer, changing inputs.
        out_ready = 1'b0;
        drive(VECS[3]);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_result("R7", VECS[3]);
        check("R7", "in_ready stalled", 64'(in_ready), 64'd0);
        drive(VECS[8]);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_result("R8", VECS[3]);
        drive(VECS[0]);
        @(posedge clk);
        @(negedge clk);
        check_result("R8", VECS[3]);

        // R7: release; pending operand enters in the same cycle.
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_result("R7", VECS[0]);
        // Back-to-back transfer.
        drive(VECS[9]);
        @(posedge clk);
        @(negedge clk);
        check_result("R7", VECS[9]);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7", "valid drop", 64'(out_valid), 64'd0);

        // R9: reset in the middle of a held result.
        out_ready = 1'b0;
        drive(VECS[0]);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9", "valid", 64'(out_valid), 64'd0);
        check("R9", "count", 64'(out_count), 64'd0);
        rst = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule